// File: doc/BRIEF.md
# Single-Step Shift Unit

This block applies one single-position shift to an operand word and keeps the result in a register. There are six shift kinds. Two are logical: they bring a zero in at the end that is left empty. Two are rotates: the bit that falls off one end comes back in at the other end. Two are arithmetic, for signed two's-complement words. A 3-bit code picks the kind. A load strobe commits the result on the next rising clock edge.

Arithmetic left moves the bits the same way as logical left. It also raises an overflow flag when the sign of the word would change, which is the case when the two top bits of the operand differ. Arithmetic right leaves the top bit where it is and copies it into the position below it, so the signed value is halved and rounded toward minus infinity.

A control decoder turns the code into a small set of strobes. A datapath builds the shifted word and holds the result register and the flag.

Top module: `shift_unit`

## Requirements
- R1: While the active-low reset `rstN` is low, `regOut` is all zeros and `ovfOut` is 0.
- R2: On an edge where `loadEn` is 0, `regOut` and `ovfOut` both keep their values.
- R3: Code 3'b000 (logical left) loads `{dataIn[W-2:0],0}`.
- R4: Code 3'b001 (logical right) loads `{0,dataIn[W-1:1]}`.
- R5: Code 3'b010 (rotate left) loads `{dataIn[W-2:0],dataIn[W-1]}`.
- R6: Code 3'b011 (rotate right) loads `{dataIn[0],dataIn[W-1:1]}`.
- R7: Code 3'b100 (arithmetic left) loads the same word as code 3'b000.
- R8: On a load with code 3'b100, `ovfOut` becomes `dataIn[W-1] ^ dataIn[W-2]`.
- R9: Code 3'b101 (arithmetic right) loads `{dataIn[W-1],dataIn[W-1:1]}`. The top bit keeps its value and bit W-2 receives a copy of it.
- R10: A load with code 3'b110 or 3'b111 leaves `regOut` unchanged and clears `ovfOut`.
- R11: A load with any code other than 3'b100 clears `ovfOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Commit the selected shift on this edge |
| opSel | input | 3 | Shift kind code |
| dataIn | input | WIDTH | Operand word to be shifted |
| regOut | output | WIDTH | Result register |
| ovfOut | output | 1 | Registered signed-overflow flag for arithmetic left |

## Verification
The bench builds the block with the default WIDTH of 16. At that width the hand-picked words 0x8000, 0x4000, 0xC000, 0xFFFF, 0x0001 and 0x0000 exercise every end-bit case:
- the sign bit falls out,
- the sign bit flips,
- the overflow flag stays low for words whose two top bits are equal,
- a rotate wraps a single one or a full word.

Random operands, random codes and random load gaps then combine every code with holds and with the reserved codes 3'b110 and 3'b111.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [2:0] {
    OP_LSL  = 3'b000,
    OP_LSR  = 3'b001,
    OP_ROL  = 3'b010,
    OP_ROR  = 3'b011,
    OP_ASL  = 3'b100,
    OP_ASR  = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } shift_op_t;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_WRAP = 2'd1,
    FILL_SIGN = 2'd2
  } fill_t;

  typedef struct packed {
    logic  regWe;
    logic  flagWe;
    logic  goLeft;
    fill_t fill;
    logic  takeOvf;
  } shift_ctrl_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic        loadEn,
  input  logic [2:0]  opSel,
  output shift_ctrl_t strobes
);

  shift_op_t opCode;

  always_comb begin
    opCode          = shift_op_t'(opSel);
    strobes.regWe   = 1'b0;
    strobes.flagWe  = loadEn;
    strobes.goLeft  = 1'b0;
    strobes.fill    = FILL_ZERO;
    strobes.takeOvf = 1'b0;
    case (opCode)
      OP_LSL: begin
        strobes.regWe  = loadEn;
        strobes.goLeft = 1'b1;
      end
      OP_LSR: begin
        strobes.regWe  = loadEn;
      end
      OP_ROL: begin
        strobes.regWe  = loadEn;
        strobes.goLeft = 1'b1;
        strobes.fill   = FILL_WRAP;
      end
      OP_ROR: begin
        strobes.regWe  = loadEn;
        strobes.fill   = FILL_WRAP;
      end
      OP_ASL: begin
        strobes.regWe   = loadEn;
        strobes.goLeft  = 1'b1;
        strobes.takeOvf = 1'b1;
      end
      OP_ASR: begin
        strobes.regWe  = loadEn;
        strobes.fill   = FILL_SIGN;
      end
      default: begin
        strobes.regWe  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  shift_ctrl_t      strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] regOut,
  output logic             ovfOut
);

  localparam int MSB = WIDTH - 1;

  logic             leftFill;
  logic             rightFill;
  logic [MSB:0]     leftVal;
  logic [MSB:0]     rightVal;
  logic [MSB:0]     nextVal;
  logic             ovfNext;
  logic [MSB:0]     resultQ;
  logic             flagQ;

  // Serial inputs at the two ends of the word
  always_comb begin
    leftFill = (strobes.fill == FILL_WRAP) ? dataIn[MSB] : 1'b0;
    case (strobes.fill)
      FILL_WRAP: rightFill = dataIn[0];
      FILL_SIGN: rightFill = dataIn[MSB];
      default:   rightFill = 1'b0;
    endcase
  end

  // Per-bit neighbour selection
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign leftVal[i]  = leftFill;
      assign rightVal[i] = dataIn[i+1];
    end else if (i == MSB) begin : g_msb
      assign leftVal[i]  = dataIn[i-1];
      assign rightVal[i] = rightFill;
    end else begin : g_mid
      assign leftVal[i]  = dataIn[i-1];
      assign rightVal[i] = dataIn[i+1];
    end
  end

  assign nextVal = strobes.goLeft ? leftVal : rightVal;
  assign ovfNext = strobes.takeOvf & (dataIn[MSB] ^ dataIn[MSB-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      flagQ   <= 1'b0;
    end else begin
      if (strobes.regWe)  resultQ <= nextVal;
      if (strobes.flagWe) flagQ   <= ovfNext;
    end
  end

  assign regOut = resultQ;
  assign ovfOut = flagQ;

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] regOut,
  output logic             ovfOut
);

  shift_ctrl_t strobes;

  shift_ctrl u_ctrl (
    .loadEn  (loadEn),
    .opSel   (opSel),
    .strobes (strobes)
  );

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .regOut  (regOut),
    .ovfOut  (ovfOut)
  );

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadEn,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] regOut,
  input logic             ovfOut
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (regOut == '0) && !ovfOut);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(regOut) && $stable(ovfOut));

  p_lsl_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == 3'b000) |=> regOut == {$past(dataIn[WIDTH-2:0]), 1'b0});

  p_asl_ovf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == 3'b100) |=> ovfOut == ($past(dataIn[WIDTH-1]) ^ $past(dataIn[WIDTH-2])));

  p_asr_sign_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel == 3'b101) |=> (regOut[WIDTH-1] == $past(dataIn[WIDTH-1]))
                                  && (regOut[WIDTH-2] == $past(dataIn[WIDTH-1])));

  p_reserved_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel[2:1] == 2'b11) |=> (regOut == $past(regOut)) && !ovfOut);

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel != 3'b100) |=> !ovfOut);

endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_shift_unit.sv
`timescale 1ns/1ps
module sim_shift_unit;

  localparam int W = 16;

  typedef struct {
    logic [W-1:0] expReg;
    logic         expOvf;
    string        regTag;
    string        ovfTag;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadEn = 1'b0;
  logic [2:0]   opSel = 3'b000;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] regOut;
  logic         ovfOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t q[$];
  logic [W-1:0] mReg = '0;
  logic         mOvf = 1'b0;

  always #2.5 clk = ~clk;

  shift_unit #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .opSel(opSel),
    .dataIn(dataIn), .regOut(regOut), .ovfOut(ovfOut)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, pushes expected result
  task automatic drive(logic ld, logic [2:0] op, logic [W-1:0] d);
    item_t it;
    @(negedge clk);
    loadEn = ld; opSel = op; dataIn = d;
    if (!ld) begin
      it.regTag = "R2"; it.ovfTag = "R2";
    end else begin
      case (op)
        3'b000: begin mReg = d << 1;                   it.regTag = "R3"; end
        3'b001: begin mReg = d >> 1;                   it.regTag = "R4"; end
        3'b010: begin mReg = {d[W-2:0], d[W-1]};       it.regTag = "R5"; end
        3'b011: begin mReg = {d[0], d[W-1:1]};         it.regTag = "R6"; end
        3'b100: begin mReg = d <<< 1;                  it.regTag = "R7"; end
        3'b101: begin mReg = W'($signed(d) >>> 1);     it.regTag = "R9"; end
        default:                                       it.regTag = "R10";
      endcase
      if (op == 3'b100) begin
        mOvf = d[W-1] ^ d[W-2]; it.ovfTag = "R8";
      end else begin
        mOvf = 1'b0; it.ovfTag = (op[2:1] == 2'b11) ? "R10" : "R11";
      end
    end
    it.expReg = mReg; it.expOvf = mOvf;
    q.push_back(it);
  endtask

  // Monitor: compares after the edge that commits each item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.regTag, regOut, it.expReg);
        check({it.ovfTag, " flag"}, W'(ovfOut), W'(it.expOvf));
      end
    end
  end

  initial begin
    #60000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [W-1:0] corners [6] = '{16'h8000, 16'h4000, 16'hC000, 16'hFFFF, 16'h0001, 16'h0000};

  initial begin
    loadEn = 1'b1; opSel = 3'b010; dataIn = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", regOut, '0);
    check("R1 reset flag", W'(ovfOut), '0);
    loadEn = 1'b0;
    rstN = 1'b1;

    // R3..R9 corner operands on every code
    for (int c = 0; c < 6; c++) begin
      for (int op = 0; op < 8; op++) begin
        drive(1'b1, 3'(op), corners[c]);
        drive(1'b0, 3'(op), ~corners[c]);
      end
    end
    // R8 overflow set, then R10 reserved code clears it and holds word
    drive(1'b1, 3'b100, 16'h4000);
    drive(1'b1, 3'b110, 16'h1234);
    drive(1'b1, 3'b100, 16'h8001);
    drive(1'b1, 3'b111, 16'hABCD);
    // R2 hold while the flag is set
    drive(1'b1, 3'b100, 16'hBFFF);
    drive(1'b0, 3'b001, 16'h0000);
    // R11 non-arithmetic load clears the flag
    drive(1'b1, 3'b011, 16'h5555);

    for (int k = 0; k < 600; k++) begin
      drive(($urandom % 4) != 0, 3'($urandom), W'($urandom));
    end

    @(negedge clk);
    loadEn = 1'b0;
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule